// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between an on-chip request port and an external asynchronous static RAM of 128K sixteen-bit words. Each request moves one word. The request carries a direction, a 17-bit word address, write data and a two-bit lane mask. The block turns it into a timed sequence of active-low strobes: chip enable, write enable, output enable and one select per byte lane. It also drives the address pins and the data-pin drive enable. The block finishes one request before it accepts the next, and the request port follows a valid/ready handshake. A read result appears on a data register together with a one-cycle strobe.

Every phase length is set in clock cycles. Each one is the RAM's nanosecond minimum divided by the clock period and rounded up, so the same code meets the RAM's timing at any clock rate. A write holds address and chip enable for a setup phase, then pulses write enable, then keeps one hold cycle. Output enable stays high for the whole write. After a read, the block waits for the RAM's outputs to turn off before it drives the data pins again.

Top module: `sram_async_ctrl`

## Requirements
- R1: While rst_ni is low, all five RAM strobes are high, the data drive enable is low, rd_valid_o is low and req_ready_o is high.
- R2: Whenever chip enable is high, write enable, output enable and both lane selects are high and the data pins are not driven.
- R3: Write enable goes low only while chip enable is low. It stays low for at least max(ceil(35/T), ceil(30/T)) clock cycles, where T is the clock period in ns. During that window the data pins are driven and hold one value.
- R4: The RAM address changes only at an edge where write enable is high both before and after that edge.
- R5: From an address change to the rising edge of write enable that ends the write, at least ceil(70/T) cycles pass.
- R6: Mask bit 0 pulls the lower select (data bits 7:0) low and mask bit 1 pulls the upper select (bits 15:8) low, for the whole transaction. A write leaves an unmasked lane of the word unchanged.
- R7: Output enable stays high throughout a write. Output enable and write enable are never low together.
- R8: rd_valid_o is high for exactly one cycle. It is set by the clock edge that comes ceil(70/T) edges after the edge that accepted the read. rd_data_o then holds the RAM word, with each lane outside the request mask forced to zero.
- R9: After output enable rises, the data drive enable stays low for at least ceil(30/T) cycles. The data pins are never driven while the RAM drives them.
- R10: req_ready_o is low whenever chip enable is low. A read request is accepted in the cycle in which rd_valid_o is high.
- R11: rd_data_o keeps its value between read strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rd_valid_o | output | 1 | One-cycle read result strobe |
| rd_data_o | output | 16 | Read result register |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_lb_no | output | 1 | Lower lane select, active low |
| sram_ub_no | output | 1 | Upper lane select, active low |
| sram_addr_o | output | 17 | RAM address pins |
| sram_dq_o | output | 16 | Data to RAM pins |
| sram_dq_i | input | 16 | Data from RAM pins |
| sram_dq_oe_o | output | 1 | Data pin drive enable |

## Verification
The bench builds the block with its default parameters: a 5 ns period and the 70 ns speed figures. That gives a 7-cycle write pulse, a 7-cycle address setup, a 14-cycle read access and a 6-cycle bus turnaround. Every phase therefore spans many clocks. An off-by-one in any counter shows up as a measurable shortfall against the bench's RAM model. This model returns wrong data until a full access time has passed. It also returns a filler byte on lanes that are not selected, which makes the zero-forcing of unmasked lanes and the timing of the capture edge directly visible.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RACC
  } sram_st_e;

  function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_timer.sv
module sram_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_sel.sv
module sram_lane_sel #(
  parameter int unsigned NL = 2
) (
  input  logic [NL-1:0]   be_i,
  output logic [NL-1:0]   sel_no,
  output logic [NL*8-1:0] mask_o
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign sel_no[g]       = ~be_i[g];
    assign mask_o[g*8 +: 8] = {8{be_i[g]}};
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned T_WC_NS       = 70,
  parameter int unsigned T_WP_NS       = 35,
  parameter int unsigned T_DS_NS       = 30,
  parameter int unsigned T_AA_NS       = 70,
  parameter int unsigned T_HZ_NS       = 30,
  parameter int unsigned AW            = 17,
  parameter int unsigned DW            = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_we_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  input  logic [DW/8-1:0] req_be_i,
  output logic            rd_valid_o,
  output logic [DW-1:0]   rd_data_o,
  output logic            sram_ce_no,
  output logic            sram_we_no,
  output logic            sram_oe_no,
  output logic            sram_lb_no,
  output logic            sram_ub_no,
  output logic [AW-1:0]   sram_addr_o,
  output logic [DW-1:0]   sram_dq_o,
  input  logic [DW-1:0]   sram_dq_i,
  output logic            sram_dq_oe_o
);
  localparam int unsigned NL     = DW / 8;
  localparam int unsigned WP_CYC = umax(umax(cdiv(T_WP_NS, CLK_PERIOD_NS),
                                             cdiv(T_DS_NS, CLK_PERIOD_NS)), 1);
  localparam int unsigned AW_CYC = umax(cdiv(T_WC_NS, CLK_PERIOD_NS), WP_CYC + 1);
  localparam int unsigned SU_CYC = AW_CYC - WP_CYC;
  localparam int unsigned RD_CYC = umax(cdiv(T_AA_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned TA_CYC = cdiv(T_HZ_NS, CLK_PERIOD_NS);
  localparam int unsigned CMAX   = umax(umax(SU_CYC, WP_CYC), umax(RD_CYC, TA_CYC));
  localparam int unsigned CW     = $clog2(CMAX + 1);

  sram_st_e        st_q;
  logic            accept;
  logic            ph_load, ph_zero, ta_load, ta_zero;
  logic [CW-1:0]   ph_val;
  logic [NL-1:0]   lane_sel_n, sel_nq;
  logic [DW-1:0]   lane_mask, mask_q;

  sram_lane_sel #(.NL(NL)) u_lane (
    .be_i   (req_be_i),
    .sel_no (lane_sel_n),
    .mask_o (lane_mask)
  );

  // phase length counter, loaded with (cycles - 1) on phase entry
  sram_timer #(.W(CW)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ph_load),
    .val_i  (ph_val),
    .zero_o (ph_zero)
  );

  // bus turnaround after the RAM stops driving
  sram_timer #(.W(CW)) u_turn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ta_load),
    .val_i  (CW'(TA_CYC)),
    .zero_o (ta_zero)
  );

  assign req_ready_o = (st_q == ST_IDLE) && (!req_we_i || ta_zero);
  assign accept      = req_valid_i && req_ready_o;
  assign ta_load     = (st_q == ST_RACC) && ph_zero;

  always_comb begin
    ph_load = 1'b0;
    ph_val  = '0;
    if (accept) begin
      ph_load = 1'b1;
      ph_val  = req_we_i ? CW'(SU_CYC - 1) : CW'(RD_CYC - 1);
    end else if (st_q == ST_WSET && ph_zero) begin
      ph_load = 1'b1;
      ph_val  = CW'(WP_CYC - 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      sram_ce_no   <= 1'b1;
      sram_we_no   <= 1'b1;
      sram_oe_no   <= 1'b1;
      sel_nq       <= '1;
      mask_q       <= '0;
      sram_addr_o  <= '0;
      sram_dq_o    <= '0;
      sram_dq_oe_o <= 1'b0;
      rd_valid_o   <= 1'b0;
      rd_data_o    <= '0;
    end else begin
      rd_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          sram_addr_o <= req_addr_i;
          sel_nq      <= lane_sel_n;
          mask_q      <= lane_mask;
          sram_ce_no  <= 1'b0;
          if (req_we_i) begin
            sram_dq_o    <= req_wdata_i;
            sram_dq_oe_o <= 1'b1;
            st_q         <= ST_WSET;
          end else begin
            sram_oe_no <= 1'b0;
            st_q       <= ST_RACC;
          end
        end
        ST_WSET: if (ph_zero) begin
          sram_we_no <= 1'b0;
          st_q       <= ST_WPUL;
        end
        ST_WPUL: if (ph_zero) begin
          sram_we_no <= 1'b1;
          st_q       <= ST_WHLD;
        end
        ST_WHLD: begin
          // we already high: hold data and address one cycle, then release
          sram_ce_no   <= 1'b1;
          sel_nq       <= '1;
          sram_dq_oe_o <= 1'b0;
          st_q         <= ST_IDLE;
        end
        ST_RACC: if (ph_zero) begin
          rd_data_o  <= sram_dq_i & mask_q;
          rd_valid_o <= 1'b1;
          sram_ce_no <= 1'b1;
          sram_oe_no <= 1'b1;
          sel_nq     <= '1;
          st_q       <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sram_lb_no = sel_nq[0];
  assign sram_ub_no = sel_nq[1];
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned T_WP_NS       = 35,
  parameter int unsigned T_DS_NS       = 30,
  parameter int unsigned T_HZ_NS       = 30,
  parameter int unsigned AW            = 17,
  parameter int unsigned DW            = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          rd_valid_o,
  input logic          sram_ce_no,
  input logic          sram_we_no,
  input logic          sram_oe_no,
  input logic          sram_lb_no,
  input logic          sram_ub_no,
  input logic [AW-1:0] sram_addr_o,
  input logic [DW-1:0] sram_dq_o,
  input logic          sram_dq_oe_o
);
  localparam int unsigned WP_MIN = umax(cdiv(T_WP_NS, CLK_PERIOD_NS), cdiv(T_DS_NS, CLK_PERIOD_NS));
  localparam int unsigned TA_MIN = cdiv(T_HZ_NS, CLK_PERIOD_NS);

  logic [15:0] we_low_cnt, oe_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_cnt <= '0;
      oe_hi_cnt  <= '1;
    end else begin
      if (!sram_we_no) we_low_cnt <= (we_low_cnt == '1) ? we_low_cnt : we_low_cnt + 1'b1;
      else             we_low_cnt <= '0;
      if (!sram_oe_no) oe_hi_cnt <= '0;
      else             oe_hi_cnt <= (oe_hi_cnt == '1) ? oe_hi_cnt : oe_hi_cnt + 1'b1;
    end
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_ce_no |-> (sram_we_no && sram_oe_no && sram_lb_no && sram_ub_no && !sram_dq_oe_o));
  // R3
  we_in_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (!sram_ce_no && sram_dq_oe_o));
  // R3
  wr_data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no && $past(!sram_we_no)) |-> $stable(sram_dq_o));
  // R3
  we_pulse_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (we_low_cnt >= 16'(WP_MIN)));
  // R4
  addr_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sram_addr_o) |-> (sram_we_no && $past(sram_we_no)));
  // R7
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_oe_no);
  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
  // R9
  turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> (oe_hi_cnt >= 16'(TA_MIN)));
  // R10
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_ce_no |-> !req_ready_o);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .T_WP_NS       (T_WP_NS),
  .T_DS_NS       (T_DS_NS),
  .T_HZ_NS       (T_HZ_NS),
  .AW            (AW),
  .DW            (DW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .rd_valid_o   (rd_valid_o),
  .sram_ce_no   (sram_ce_no),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no),
  .sram_lb_no   (sram_lb_no),
  .sram_ub_no   (sram_ub_no),
  .sram_addr_o  (sram_addr_o),
  .sram_dq_o    (sram_dq_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
  localparam int PER    = 5;
  localparam int RD_EXP = (70 + PER - 1) / PER;
  localparam int WP_A   = (35 + PER - 1) / PER;
  localparam int WP_B   = (30 + PER - 1) / PER;
  localparam int WP_EXP = (WP_A > WP_B) ? WP_A : WP_B;
  localparam int AW_EXP = (70 + PER - 1) / PER;
  localparam int TA_EXP = (30 + PER - 1) / PER;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o, req_we_i = 1'b0;
  logic [16:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [1:0]  req_be_i = '0;
  logic rd_valid_o;
  logic [15:0] rd_data_o;
  logic sram_ce_no, sram_we_no, sram_oe_no, sram_lb_no, sram_ub_no, sram_dq_oe_o;
  logic [16:0] sram_addr_o;
  logic [15:0] sram_dq_o, sram_dq_i;

  always #2.5 clk = ~clk;

  sram_async_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_be_i(req_be_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .sram_ce_no(sram_ce_no), .sram_we_no(sram_we_no), .sram_oe_no(sram_oe_no),
    .sram_lb_no(sram_lb_no), .sram_ub_no(sram_ub_no), .sram_addr_o(sram_addr_o),
    .sram_dq_o(sram_dq_o), .sram_dq_i(sram_dq_i), .sram_dq_oe_o(sram_dq_oe_o)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- RAM model and reference ----------------
  logic [15:0] ram [int];
  logic [15:0] refm [int];
  logic [15:0] q_dat [$];
  int          q_cyc [$];

  function automatic logic [15:0] ram_get(input int a);
    return ram.exists(a) ? ram[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] ref_get(input int a);
    return refm.exists(a) ? refm[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] be_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  logic [15:0] rd_word = '0;
  int rcnt = 0;
  logic rd_act;
  assign rd_act = !sram_ce_no && !sram_oe_no && sram_we_no;
  assign sram_dq_i[7:0]  = (rd_act && !sram_lb_no) ? ((rcnt >= RD_EXP) ? rd_word[7:0]  : 8'hAD) : 8'hEE;
  assign sram_dq_i[15:8] = (rd_act && !sram_ub_no) ? ((rcnt >= RD_EXP) ? rd_word[15:8] : 8'hAD) : 8'hEE;

  logic [16:0] prev_addr = '0, waddr = '0;
  logic prev_we_n = 1'b1, prev_dqoe = 1'b0, have_last = 1'b0;
  logic [1:0] cur_be = '0, wsel_n = '1;
  logic [15:0] wdat = '0, last_rd = '0;
  int t_addr = 0, wcnt = 0, oe_hi = 1000000;

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      // R2: quiet bus while deselected
      if (sram_ce_no)
        chk(sram_we_no && sram_oe_no && sram_lb_no && sram_ub_no && !sram_dq_oe_o, "R2",
            "strobes while deselected", {27'd0, sram_we_no, sram_oe_no, sram_lb_no, sram_ub_no, sram_dq_oe_o}, 32'h1E);
      // R7
      if (!sram_we_no) chk(sram_oe_no, "R7", "oe during write pulse", sram_oe_no, 1);
      // R6: lane selects follow mask
      if (!sram_ce_no) chk({sram_ub_no, sram_lb_no} == ~cur_be, "R6", "lane selects",
                           {sram_ub_no, sram_lb_no}, ~cur_be);
      // R10
      if (!sram_ce_no) chk(!req_ready_o, "R10", "ready while busy", req_ready_o, 0);
      // R9: no contention
      chk(!(sram_dq_oe_o && rd_act), "R9", "bus contention", sram_dq_oe_o, 0);
      // R4
      if (sram_addr_o != prev_addr) begin
        chk(sram_we_no && prev_we_n, "R4", "address moved with we low", {sram_we_no, prev_we_n}, 3);
        t_addr = cyc;
      end
      // R3 / R5 write window
      if (!sram_ce_no && !sram_we_no) begin
        if (wcnt == 0) wdat = sram_dq_o;
        else chk(sram_dq_o == wdat && sram_dq_oe_o, "R3", "write data unstable", sram_dq_o, wdat);
        wcnt++;
        waddr = sram_addr_o;
        wsel_n = {sram_ub_no, sram_lb_no};
      end else if (wcnt > 0) begin
        chk(wcnt >= WP_EXP, "R3", "write pulse cycles", wcnt, WP_EXP);
        chk(cyc - t_addr >= AW_EXP, "R5", "address to end of write", cyc - t_addr, AW_EXP);
        ram[int'(waddr)] = {wsel_n[1] ? ram_get(int'(waddr)) >> 8 : {8'h00, wdat[15:8]}, 8'h00} |
                           {8'h00, wsel_n[0] ? ram_get(int'(waddr)) & 16'h00FF : {8'h00, wdat[7:0]}};
        wcnt = 0;
      end
      // R9 turnaround
      if (sram_dq_oe_o && !prev_dqoe)
        chk(oe_hi >= TA_EXP, "R9", "turnaround cycles", oe_hi, TA_EXP);
      if (!sram_oe_no) oe_hi = 0;
      else if (oe_hi < 1000000) oe_hi++;
      // read access age
      if (rd_act) rcnt = (rcnt > 0 && sram_addr_o == prev_addr) ? rcnt + 1 : 1;
      else rcnt = 0;
      // R8 / R11 result checks
      if (rd_valid_o) begin
        if (q_dat.size() == 0) chk(1'b0, "R8", "unexpected read strobe", 1, 0);
        else begin
          automatic logic [15:0] ed = q_dat.pop_front();
          automatic int ec = q_cyc.pop_front();
          chk(rd_data_o == ed, "R8", "read data", rd_data_o, ed);
          chk(cyc == ec, "R8", "read strobe cycle", cyc, ec);
        end
        // R10: read accepted while strobe high
        if (req_valid_i && !req_we_i) chk(req_ready_o, "R10", "read ready at strobe", req_ready_o, 1);
        last_rd = rd_data_o;
        have_last = 1'b1;
      end else if (have_last) begin
        chk(rd_data_o == last_rd, "R11", "read data held", rd_data_o, last_rd);
      end
      // accept: reference model update
      if (req_valid_i && req_ready_o) begin
        cur_be = req_be_i;
        if (req_we_i)
          refm[int'(req_addr_i)] = (ref_get(int'(req_addr_i)) & ~be_mask(req_be_i)) |
                                   (req_wdata_i & be_mask(req_be_i));
        else begin
          q_dat.push_back(ref_get(int'(req_addr_i)) & be_mask(req_be_i));
          q_cyc.push_back(cyc + 1 + RD_EXP);
        end
      end
    end
    prev_addr = sram_addr_o;
    prev_we_n = sram_we_no;
    prev_dqoe = sram_dq_oe_o;
    rd_word   = ram_get(int'(sram_addr_o));
  end

  task automatic req(input bit we, input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
    @(posedge clk); #1;
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = d; req_be_i = be;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    @(posedge clk); #1;
    req_valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sram_ce_no && sram_we_no && sram_oe_no, "R1", "strobes in reset",
        {sram_ce_no, sram_we_no, sram_oe_no}, 7);
    chk(sram_lb_no && sram_ub_no, "R1", "lane selects in reset", {sram_lb_no, sram_ub_no}, 3);
    chk(!sram_dq_oe_o, "R1", "drive enable in reset", sram_dq_oe_o, 0);
    chk(!rd_valid_o, "R1", "strobe in reset", rd_valid_o, 0);
    chk(req_ready_o, "R1", "ready in reset", req_ready_o, 1);
    @(posedge clk); #1 rst_ni = 1'b1;

    // full word, then masked lanes (R6)
    req(1, 17'h00010, 16'h1234, 2'b11);
    req(0, 17'h00010, 16'h0000, 2'b11);
    req(1, 17'h00010, 16'hFFCD, 2'b01);
    req(0, 17'h00010, 16'h0000, 2'b11);
    req(1, 17'h00010, 16'h5AFF, 2'b10);
    req(0, 17'h00010, 16'h0000, 2'b11);
    // partial reads force unmasked lanes to zero (R8)
    req(0, 17'h00010, 16'h0000, 2'b01);
    req(0, 17'h00010, 16'h0000, 2'b10);
    // empty mask write changes nothing (R6)
    req(1, 17'h00010, 16'h0000, 2'b00);
    req(0, 17'h00010, 16'h0000, 2'b11);
    // address extremes
    req(1, 17'h00000, 16'hA5A5, 2'b11);
    req(1, 17'h1FFFF, 16'h3C3C, 2'b11);
    req(0, 17'h1FFFF, 16'h0000, 2'b11);
    req(0, 17'h00000, 16'h0000, 2'b11);
    // read immediately followed by write: turnaround (R9)
    req(1, 17'h1FFFF, 16'hC001, 2'b11);
    req(0, 17'h1FFFF, 16'h0000, 2'b11);
    // mixed pattern
    begin
      automatic int unsigned s = 32'h1;
      for (int i = 0; i < 24; i++) begin
        s = s * 32'd1103515245 + 32'd12345;
        req(s[5], 17'h00100 + 17'(s[20:18]), s[31:16], s[9:8]);
      end
    end
    repeat (40) @(negedge clk);
    chk(q_dat.size() == 0, "R8", "reads outstanding at end", q_dat.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule